// File: doc/BRIEF.md
# MDIO Management Controller

This block is a management-bus master for Ethernet PHYs. A processor programs it through a small word-addressed register port. The block then serializes management frames onto the MDC clock and the MDIO data line. It deserializes the data that a PHY returns during read frames. One register set serves both the short frame format (clause 22) and the extended format (clause 45). A mode bit in the configuration register selects which format is used.

Software starts a transaction by a register write. In extended mode, a write to the address register sends an address frame. A write to the data register sends a write frame, using the PHY and device fields held in the control register. A control write with the read bit set sends a read frame, and the 16 captured bits land in the data register. Two busy flags tell software when a frame is in flight. A sticky error flag reports a PHY that did not answer. MDC comes from a programmable divider of the system clock, so it can be held at or below 2.5 MHz. For example, a divider of 258 on a fast core clock keeps MDC within that limit.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, MDC and the output enable are low, the PHY-side output is high, and the configuration (offset 0), control (offset 1) and data (offset 2) registers read as zero.
- R2: The configuration register holds the divider in bits [8+DIV_W-1:8]. With a nonzero divider D, MDC is high for D system clocks and low for D system clocks. With D = 0, MDC is held low.
- R3: A short-format write frame sends 32 ones, start 01, opcode 01, the 5-bit PHY address (control bits [9:5]), the 5-bit register number (control bits [4:0]), turnaround 10 and the 16 data bits, most significant bit first. The frame is sent on a write to the data register (offset 2, bits [15:0]). MDIO and its enable change only when MDC falls.
- R4: A control write (offset 1) with bit 15 set sends a read frame. The start and opcode are 01 10 in short format and 00 11 in extended format. The block drives only the first 46 bits. It releases the enable from the turnaround onward. The 16 bits sampled on MDC rising edges, most significant first, appear in data register bits [15:0].
- R5: The mode bit is configuration bit 0 (1 = extended, 0 = short). In extended mode, a write to the address register (offset 3, bits [15:0]) sends start 00, opcode 00, the PHY and device fields, turnaround 10 and the address. Configuration bit 1 (bus busy) reads 1 while that frame is in progress. In short mode, an address-register write sends no frame.
- R6: In extended mode, a data-register write sends start 00 and opcode 01, with the device field in place of the register number.
- R7: Data register bit 31 reads 1 while a read or write frame is in progress. Each busy flag clears one MDC period after the last frame bit, which is 66 MDC falling edges after the command for a 32-bit preamble.
- R8: If the line is not low at the second turnaround bit of a read, configuration bit 2 (read error) is set when the frame ends. Bit 2 is cleared when the next read is launched.
- R9: While either busy flag is set, writes to the control, address and data registers are ignored and launch nothing. This includes the read command.
- R10: req_ready is always high. Every read request returns rsp_valid for one cycle, on the cycle after it is accepted, together with rsp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word offset: 0 config/status, 1 control, 2 data, 3 address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| mdc | output | 1 | Management clock to PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The bench builds the block with its default parameters: a 9-bit divider and a 32-bit preamble. So every frame checked is full length, and the divider's largest recommended setting of 258 is measured directly. Most frames run with a divider of 4. This makes an MDC period eight system clocks, which is long enough for register polling to catch the exact falling edge on which a busy flag drops. It is also short enough to run a dozen complete frames in both formats, including a read with a missing turnaround.

// File: rtl/mdio_pkg.sv
// Package: shared types and register offsets for the MDIO management controller.
// Assumes a word-addressed register port with four locations.
package mdio_pkg;
    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } mdio_op_e;

    localparam logic [1:0] OFS_CFG  = 2'd0;
    localparam logic [1:0] OFS_CTRL = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;
    localparam logic [1:0] OFS_ADDR = 2'd3;

    localparam int CTRL_RD_BIT   = 15;
    localparam int CFG_MODE_BIT  = 0;
    localparam int CFG_BUSY_BIT  = 1;
    localparam int CFG_ERR_BIT   = 2;
    localparam int CFG_DIV_LSB   = 8;
    localparam int DATA_BUSY_BIT = 31;
endpackage

// File: rtl/mdio_clkgen.sv
// Module: MDC generator. The half-period is DIV system clocks, and DIV = 0 stops MDC low.
// It gives single-cycle tick strobes on the system-clock edge where MDC rises or falls.
// Assumes the divider may change at any time and takes effect on the next compare.
module mdio_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    // The half-period ends once the count reaches the divider.
    assign wrap      = (div != '0) && (cnt >= div - 1'b1);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // The counter and the MDC toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (div == '0) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: the frame serializer and deserializer. It loads a whole frame on start,
// shifts one bit out on each MDC fall and samples read data on each MDC rise.
// It stays busy one MDC period past the final bit.
// Assumes start is only pulsed while idle.
module mdio_frame_engine #(
    parameter int PRE_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  mdio_pkg::mdio_op_e op,
    input  logic               c45,
    input  logic [4:0]         port,
    input  logic [4:0]         dev,
    input  logic [15:0]        wdata,
    input  logic               fall_tick,
    input  logic               rise_tick,
    input  logic               mdio_i,
    output logic               busy,
    output mdio_pkg::mdio_op_e cur_op,
    output logic               done,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [15:0]        rdata,
    output logic               rd_err
);
    import mdio_pkg::*;

    localparam int FRAME_BITS = PRE_BITS + 32;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int LAST_POS   = FRAME_BITS - 1;
    localparam int TA_POS     = PRE_BITS + 14;
    localparam int TA2_POS    = PRE_BITS + 15;
    localparam int DATA_POS   = PRE_BITS + 16;

    typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_SHIFT, PH_TAIL} phase_e;

    phase_e                phase;
    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W-1:0]      idx_nxt;

    // Builds the full bit image of a frame, first bit at the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input mdio_op_e   f_op,
        input logic       f_c45,
        input logic [4:0] f_port,
        input logic [4:0] f_dev,
        input logic [15:0] f_data
    );
        logic [1:0]  st;
        logic [1:0]  opc;
        logic [15:0] body;
        st = f_c45 ? 2'b00 : 2'b01;
        case (f_op)
            OP_ADDR:  opc = 2'b00;
            OP_WRITE: opc = 2'b01;
            default:  opc = f_c45 ? 2'b11 : 2'b10;
        endcase
        body = (f_op == OP_READ) ? 16'hFFFF : f_data;
        return {{PRE_BITS{1'b1}}, st, opc, f_port, f_dev, 2'b10, body};
    endfunction

    assign busy    = (phase != PH_IDLE);
    assign done    = (phase == PH_TAIL) && fall_tick;
    assign idx_nxt = idx + 1'b1;

    // Frame sequencing: load, shift out on falls, sample on rises, then a tail period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            idx     <= '0;
            cur_op  <= OP_ADDR;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rdata   <= '0;
            rd_err  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        shreg  <= build_frame(op, c45, port, dev, wdata);
                        cur_op <= op;
                        phase  <= PH_WAIT;
                        if (op == OP_READ) begin
                            rd_err <= 1'b0;
                        end
                    end
                end
                PH_WAIT: begin
                    if (fall_tick) begin
                        mdio_o  <= shreg[FRAME_BITS-1];
                        mdio_oe <= 1'b1;
                        shreg   <= shreg << 1;
                        idx     <= '0;
                        phase   <= PH_SHIFT;
                    end
                end
                PH_SHIFT: begin
                    if (fall_tick) begin
                        if (idx == IDX_W'(LAST_POS)) begin
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b1;
                            phase   <= PH_TAIL;
                        end else begin
                            idx     <= idx_nxt;
                            mdio_o  <= shreg[FRAME_BITS-1];
                            shreg   <= shreg << 1;
                            mdio_oe <= !((cur_op == OP_READ) && (idx_nxt >= IDX_W'(TA_POS)));
                        end
                    end else if (rise_tick && (cur_op == OP_READ)) begin
                        if (idx == IDX_W'(TA2_POS)) begin
                            rd_err <= mdio_i;
                        end
                        if (idx >= IDX_W'(DATA_POS)) begin
                            rdata <= {rdata[14:0], mdio_i};
                        end
                    end
                end
                default: begin
                    if (fall_tick) begin
                        phase <= PH_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mdio_regs.sv
// Module: the register file and command decoder. It stores the configuration,
// control, address and data registers, launches frames on command writes while
// idle, and returns registered read data one cycle after a read request.
// Assumes DIV_W <= 24 so that the divider fits above bit 8.
module mdio_regs #(
    parameter int DIV_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    input  logic               eng_busy,
    input  mdio_pkg::mdio_op_e eng_op,
    input  logic               eng_done,
    input  logic [15:0]        eng_rdata,
    input  logic               eng_rd_err,
    output logic               start,
    output mdio_pkg::mdio_op_e start_op,
    output logic               c45,
    output logic [4:0]         start_port,
    output logic [4:0]         start_dev,
    output logic [15:0]        start_data,
    output logic [DIV_W-1:0]   div,
    output logic               err_flag
);
    import mdio_pkg::*;

    logic        wr_en;
    logic        go_addr;
    logic        go_wr;
    logic        go_rd;
    logic [4:0]  port_q;
    logic [4:0]  dev_q;
    logic [15:0] regaddr_q;
    logic [15:0] data_q;
    logic        bus_busy;
    logic        data_busy;
    logic [31:0] rd_mux;

    // Decode the command writes, which are accepted only while the bus is idle.
    assign wr_en   = req_valid && req_write;
    assign go_addr = wr_en && (req_addr == OFS_ADDR) && c45 && !eng_busy;
    assign go_wr   = wr_en && (req_addr == OFS_DATA) && !eng_busy;
    assign go_rd   = wr_en && (req_addr == OFS_CTRL) && req_wdata[CTRL_RD_BIT] && !eng_busy;

    assign start      = go_addr || go_wr || go_rd;
    assign start_op   = go_addr ? OP_ADDR : (go_wr ? OP_WRITE : OP_READ);
    assign start_port = go_rd ? req_wdata[9:5] : port_q;
    assign start_dev  = go_rd ? req_wdata[4:0] : dev_q;
    assign start_data = req_wdata[15:0];

    assign bus_busy  = eng_busy && (eng_op == OP_ADDR);
    assign data_busy = eng_busy && (eng_op != OP_ADDR);

    // Register storage and capture of the read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c45       <= 1'b0;
            div       <= '0;
            port_q    <= '0;
            dev_q     <= '0;
            regaddr_q <= '0;
            data_q    <= '0;
            err_flag  <= 1'b0;
        end else begin
            if (wr_en && (req_addr == OFS_CFG)) begin
                c45 <= req_wdata[CFG_MODE_BIT];
                div <= req_wdata[CFG_DIV_LSB +: DIV_W];
            end
            if (wr_en && !eng_busy) begin
                if (req_addr == OFS_CTRL) begin
                    port_q <= req_wdata[9:5];
                    dev_q  <= req_wdata[4:0];
                end
                if (req_addr == OFS_ADDR) begin
                    regaddr_q <= req_wdata[15:0];
                end
                if (req_addr == OFS_DATA) begin
                    data_q <= req_wdata[15:0];
                end
            end
            if (go_rd) begin
                err_flag <= 1'b0;
            end else if (eng_done && (eng_op == OP_READ)) begin
                err_flag <= eng_rd_err;
                data_q   <= eng_rdata;
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        rd_mux = '0;
        case (req_addr)
            OFS_CFG: begin
                rd_mux[CFG_MODE_BIT]            = c45;
                rd_mux[CFG_BUSY_BIT]            = bus_busy;
                rd_mux[CFG_ERR_BIT]             = err_flag;
                rd_mux[CFG_DIV_LSB +: DIV_W]    = div;
            end
            OFS_CTRL: rd_mux[9:0] = {port_q, dev_q};
            OFS_DATA: begin
                rd_mux[15:0]          = data_q;
                rd_mux[DATA_BUSY_BIT] = data_busy;
            end
            default:  rd_mux[15:0] = regaddr_q;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : rsp_rdata;
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Module: top of the MDIO management controller. It joins the register file,
// the MDC divider and the frame engine.
// Assumes an external tri-state buffer built from mdio_o and mdio_oe, with a pull-up.
module mdio_mgmt_ctrl #(
    parameter int DIV_W    = 9,
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [1:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_pkg::*;

    logic             eng_busy;
    mdio_op_e         eng_op;
    logic             eng_done;
    logic [15:0]      eng_rdata;
    logic             eng_rd_err;
    logic             start;
    mdio_op_e         start_op;
    logic             c45;
    logic [4:0]       start_port;
    logic [4:0]       start_dev;
    logic [15:0]      start_data;
    logic [DIV_W-1:0] cfg_div;
    logic             stat_rderr;
    logic             rise_tick;
    logic             fall_tick;

    assign req_ready = 1'b1;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .eng_busy   (eng_busy),
        .eng_op     (eng_op),
        .eng_done   (eng_done),
        .eng_rdata  (eng_rdata),
        .eng_rd_err (eng_rd_err),
        .start      (start),
        .start_op   (start_op),
        .c45        (c45),
        .start_port (start_port),
        .start_dev  (start_dev),
        .start_data (start_data),
        .div        (cfg_div),
        .err_flag   (stat_rderr)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (cfg_div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine #(.PRE_BITS(PRE_BITS)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (start_op),
        .c45       (c45),
        .port      (start_port),
        .dev       (start_dev),
        .wdata     (start_data),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .mdio_i    (mdio_i),
        .busy      (eng_busy),
        .cur_op    (eng_op),
        .done      (eng_done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdata     (eng_rdata),
        .rd_err    (eng_rd_err)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
// Module: assertion checker for mdio_mgmt_ctrl, attached with a bind statement.
// Assumes the bound top exposes eng_busy, cfg_div and stat_rderr.
module mdio_mgmt_ctrl_chk #(
    parameter int DIV_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             req_valid,
    input logic             req_write,
    input logic             rsp_valid,
    input logic             eng_busy,
    input logic [DIV_W-1:0] cfg_div,
    input logic             err_flag
);
    assert_div_zero_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div == '0) |=> !mdc);

    assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(mdio_o) |-> $fell(mdc));

    assert_oe_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(mdio_oe) |-> $fell(mdc));

    assert_busy_ends_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_busy) |-> $fell(mdc));

    assert_err_at_frame_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(err_flag) |-> ($rose(eng_busy) || $fell(eng_busy)));

    assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .eng_busy  (eng_busy),
    .cfg_div   (cfg_div),
    .err_flag  (stat_rderr)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
    localparam int DIVW = 9;
    localparam int RUN_DIV = 4;

    typedef struct packed {
        logic        c45;
        logic [1:0]  op;    // 0 address, 1 write, 2 read
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] val;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 2'd1, 5'd1,  5'd2,  16'hA5C3},
        '{1'b0, 2'd2, 5'd31, 5'd0,  16'h1234},
        '{1'b1, 2'd0, 5'd3,  5'd1,  16'h0800},
        '{1'b1, 2'd1, 5'd3,  5'd1,  16'h0001},
        '{1'b1, 2'd2, 5'd0,  5'd31, 16'h8001},
        '{1'b0, 2'd1, 5'd0,  5'd31, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_addr = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;
    bit          finished = 0;

    // The bench-side PHY and the bus monitor.
    logic        mdc_d = 1'b0;
    logic [63:0] cap = '0;
    int          ncap = 0;
    int          nfall = 0;
    int          rise_cyc = 0;
    int          prev_rise_cyc = 0;
    bit          phy_respond = 0;
    bit          phy_on = 0;
    int          phy_idx = 0;
    logic        phy_ta = 1'b0;
    logic [15:0] phy_val = '0;
    logic        oe_d = 1'b0;
    logic        phy_bit;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always_comb begin
        if (phy_idx == 0)      phy_bit = 1'b1;
        else if (phy_idx == 1) phy_bit = phy_ta;
        else if (phy_idx <= 17) phy_bit = phy_val[17 - phy_idx];
        else                   phy_bit = 1'b1;
    end

    assign mdio_i = mdio_oe ? mdio_o : (phy_on ? phy_bit : 1'b1);

    // The monitor samples away from the active edge and reacts to MDC edges.
    always @(negedge clk) begin
        if (mdc_d && !mdc) begin
            nfall = nfall + 1;
            if (phy_respond && oe_d && !mdio_oe) begin
                phy_on = 1;
                phy_idx = 0;
            end else if (phy_on) begin
                phy_idx = phy_idx + 1;
                if (phy_idx > 17) phy_on = 0;
            end
            oe_d = mdio_oe;
        end
        if (!mdc_d && mdc) begin
            prev_rise_cyc = rise_cyc;
            rise_cyc = cyc;
            if (mdio_oe) begin
                cap = {cap[62:0], mdio_o};
                ncap = ncap + 1;
            end
        end
        mdc_d = mdc;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R10 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        d = rsp_rdata;
    endtask

    task automatic wait_idle(input bit addr_frame);
        logic [31:0] r;
        for (int i = 0; i < 5000; i++) begin
            if (addr_frame) begin
                reg_rd(2'd0, r);
                if (r[1] == 1'b0) return;
            end else begin
                reg_rd(2'd2, r);
                if (r[31] == 1'b0) return;
            end
        end
        chk(0, "R7 busy never cleared", 64'd1, 64'd0);
    endtask

    function automatic logic [63:0] exp_frame(input logic c45, input logic [1:0] op,
                                              input logic [4:0] port, input logic [4:0] dev,
                                              input logic [15:0] val);
        logic [1:0] st;
        logic [1:0] opc;
        st = c45 ? 2'b00 : 2'b01;
        if (op == 2'd0)      opc = 2'b00;
        else if (op == 2'd1) opc = 2'b01;
        else                 opc = c45 ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, st, opc, port, dev, 2'b10, val};
    endfunction

    initial begin
        while (!finished) begin
            @(posedge clk);
            if (cyc > 190000) begin
                chk(0, "watchdog expired", cyc, 190000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] r;
        logic [63:0] ef;
        int          b_cap;
        int          b_fall;
        int          r0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: the reset state
        chk(mdc === 1'b0, "R1 mdc", {63'd0, mdc}, 0);
        chk(mdio_oe === 1'b0, "R1 oe", {63'd0, mdio_oe}, 0);
        chk(mdio_o === 1'b1, "R1 mdio_o", {63'd0, mdio_o}, 1);
        chk(req_ready === 1'b1, "R10 ready", {63'd0, req_ready}, 1);
        reg_rd(2'd0, r); chk(r == 0, "R1 cfg", r, 0);
        reg_rd(2'd1, r); chk(r == 0, "R1 ctrl", r, 0);
        reg_rd(2'd2, r); chk(r == 0, "R1 data", r, 0);

        // R2: the divider period and the stop at zero
        reg_wr(2'd0, 32'd3 << 8);
        repeat (40) @(negedge clk);
        chk(rise_cyc - prev_rise_cyc == 6, "R2 div3 period", rise_cyc - prev_rise_cyc, 6);
        reg_wr(2'd0, 32'd258 << 8);
        repeat (1200) @(negedge clk);
        chk(rise_cyc - prev_rise_cyc == 516, "R2 div258 period", rise_cyc - prev_rise_cyc, 516);
        reg_wr(2'd0, 32'd0);
        repeat (3) @(negedge clk);
        r0 = rise_cyc;
        repeat (100) @(negedge clk);
        chk(mdc === 1'b0 && rise_cyc == r0, "R2 div0 stopped", {63'd0, mdc}, 0);

        // Table of frames, walked in order (R3, R4, R5, R6, R7)
        for (int v = 0; v < 6; v++) begin
            reg_wr(2'd0, (RUN_DIV << 8) | {31'd0, VECS[v].c45});
            reg_wr(2'd1, {22'd0, VECS[v].port, VECS[v].dev});
            b_cap = ncap;
            ef = exp_frame(VECS[v].c45, VECS[v].op, VECS[v].port, VECS[v].dev, VECS[v].val);
            if (VECS[v].op == 2'd2) begin
                phy_val = VECS[v].val; phy_ta = 1'b0; phy_respond = 1;
                reg_wr(2'd1, {16'd0, 1'b1, 5'd0, VECS[v].port, VECS[v].dev});
                reg_rd(2'd2, r); chk(r[31] == 1'b1, "R7 data busy on read", r, 32'h8000_0000);
                wait_idle(0);
                chk(ncap - b_cap == 46, "R4 driven bit count", ncap - b_cap, 46);
                chk(cap[45:0] == ef[63:18], "R4 read header", cap[45:0], ef[63:18]);
                reg_rd(2'd2, r); chk(r[15:0] == VECS[v].val, "R4 read data", r[15:0], VECS[v].val);
                reg_rd(2'd0, r); chk(r[2] == 1'b0, "R8 no error", r, 0);
                phy_respond = 0;
            end else if (VECS[v].op == 2'd1) begin
                reg_wr(2'd2, {16'd0, VECS[v].val});
                reg_rd(2'd2, r); chk(r[31] == 1'b1, "R7 data busy on write", r, 32'h8000_0000);
                wait_idle(0);
                chk(ncap - b_cap == 64, "R3 bit count", ncap - b_cap, 64);
                chk(cap == ef, VECS[v].c45 ? "R6 c45 write frame" : "R3 c22 write frame", cap, ef);
            end else begin
                reg_wr(2'd3, {16'd0, VECS[v].val});
                reg_rd(2'd0, r); chk(r[1] == 1'b1, "R5 bus busy", r, 2);
                reg_rd(2'd2, r); chk(r[31] == 1'b0, "R5 data busy clear", r, 0);
                wait_idle(1);
                chk(ncap - b_cap == 64, "R5 bit count", ncap - b_cap, 64);
                chk(cap == ef, "R5 address frame", cap, ef);
            end
        end

        // R5: an address write in short mode launches nothing
        reg_wr(2'd0, RUN_DIV << 8);
        b_cap = ncap;
        reg_wr(2'd3, 32'h0000_4321);
        reg_rd(2'd0, r); chk(r[1] == 1'b0, "R5 c22 addr no busy", r, 0);
        repeat (200) @(negedge clk);
        chk(ncap == b_cap, "R5 c22 addr no frame", ncap - b_cap, 0);

        // R7: busy clears on the 66th MDC fall
        reg_wr(2'd1, {22'd0, 5'd4, 5'd7});
        b_fall = nfall;
        reg_wr(2'd2, 32'h0000_5A5A);
        wait_idle(0);
        chk(nfall - b_fall == 66, "R7 falls until idle", nfall - b_fall, 66);

        // R9: commands written while busy are ignored
        reg_wr(2'd1, {22'd0, 5'd5, 5'd6});
        b_cap = ncap;
        reg_wr(2'd2, 32'h0000_1111);
        reg_wr(2'd2, 32'h0000_2222);
        reg_wr(2'd1, {16'd0, 1'b1, 5'd0, 5'd9, 5'd9});
        wait_idle(0);
        ef = exp_frame(1'b0, 2'd1, 5'd5, 5'd6, 16'h1111);
        chk(cap == ef, "R9 frame unchanged", cap, ef);
        chk(ncap - b_cap == 64, "R9 single frame", ncap - b_cap, 64);
        reg_rd(2'd2, r); chk(r[15:0] == 16'h1111, "R9 data kept", r, 32'h1111);
        reg_rd(2'd1, r); chk(r[9:0] == {5'd5, 5'd6}, "R9 ctrl kept", r, {5'd5, 5'd6});

        // R8: a missing turnaround sets the error flag, and the next read clears it
        phy_respond = 1; phy_ta = 1'b1; phy_val = 16'hBEEF;
        reg_wr(2'd1, {16'd0, 1'b1, 5'd0, 5'd2, 5'd3});
        wait_idle(0);
        reg_rd(2'd0, r); chk(r[2] == 1'b1, "R8 error set", r, 4);
        phy_ta = 1'b0; phy_val = 16'h0F0F;
        reg_wr(2'd1, {16'd0, 1'b1, 5'd0, 5'd2, 5'd3});
        reg_rd(2'd0, r); chk(r[2] == 1'b0, "R8 error cleared on launch", r, 0);
        wait_idle(0);
        reg_rd(2'd0, r); chk(r[2] == 1'b0, "R8 error stays clear", r, 0);
        reg_rd(2'd2, r); chk(r[15:0] == 16'h0F0F, "R4 read after error", r[15:0], 16'h0F0F);
        phy_respond = 0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule